// File: doc/BRIEF.md
# Lockstep 4x4 Matrix Processing Array

This block is a square grid of sixteen 32-bit processing elements. All of them run the same operation in the same cycle. Register index k, taken across all sixteen elements, forms matrix register k: a 4x4 matrix of 32-bit words. Each element also holds two separate 40-bit multiply-accumulate registers and four condition bits. A compare operation writes those bits. A select operation reads them, so each element can pick its own result without a branch.

The operand wiring is a full mesh along rows and columns. One element per row, or one per column, can place a register value on a shared broadcast line. Every element on that line can then use the value as its second operand. The same slot can instead carry a scalar supplied with the instruction. A wide port loads a whole matrix register in one operation. A combinational read port returns any matrix register as a 512-bit word. The condition bits of all elements appear on a flag output.

Top module: `mtx_grid_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every matrix register, both accumulators of every element and all condition bits to zero.
- R2: Opcode 9 (load) writes `ldData[32*(4r+c) +: 32]` into register `instDst` of the element at row r, column c, at the next clock edge. The read port returns register `rdIdx` combinationally, with the same bit mapping.
- R3: Opcodes 1 (add), 2 (subtract) and 3 (signed multiply, low 32 bits) compute register `instSrcA` op operand B in every element at once, wrap modulo 2^32, and write the result to `instDst`. With `bcMode` 0, operand B is the element's own register `instSrcB`.
- R4: With `bcMode` 1 (row broadcast), operand B in every element of row r is register `instSrcB` of the element at row r, column `bcIdx`.
- R5: With `bcMode` 2 (column broadcast), operand B in every element of column c is register `instSrcB` of the element at row `bcIdx`, column c.
- R6: With `bcMode` 3, operand B in every element is `instScalar`.
- R7: Opcode 4 (compare) sets condition bit `instCc` of each element to the signed result of A < B and leaves its other three bits unchanged. Bit k of element (r,c) appears on `ccFlags[4*(4r+c)+k]`.
- R8: Opcode 5 (select) writes A to `instDst` where condition bit `instCc` is 1, and B where it is 0.
- R9: Opcode 6 adds the 40-bit signed product A*B into the accumulator chosen by `instCc[0]`, modulo 2^40. The other accumulator and the registers are unchanged.
- R10: Opcode 7 clears only the accumulator chosen by `instCc[0]`. Opcode 8 writes bits [39:8] of that accumulator to `instDst`.
- R11: While `instValid` is low, or for opcode 0, no register, accumulator or condition bit changes, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | Launches the instruction on this edge |
| instOp | input | 4 | Opcode |
| instDst | input | 4 | Destination register index |
| instSrcA | input | 4 | Operand A register index |
| instSrcB | input | 4 | Operand B register index (also the broadcast source register) |
| instCc | input | 2 | Condition bit index; bit 0 also selects the accumulator |
| bcMode | input | 2 | Operand B source: 0 local, 1 row, 2 column, 3 scalar |
| bcIdx | input | 2 | Column (row mode) or row (column mode) of the driving element |
| instScalar | input | 32 | Scalar operand |
| ldData | input | 512 | Full matrix word for load |
| rdIdx | input | 4 | Matrix register to read |
| rdData | output | 512 | Contents of matrix register `rdIdx` |
| ccFlags | output | 64 | Four condition bits per element |

## Verification
The hardest state to reach from the ports is an accumulator that has wrapped past 2^40. Its value is only visible through a move, and the move drops the low eight bits. The stimulus loads the largest positive and most negative words, then repeats multiply-accumulates into one accumulator while the other takes different products. Moves to registers expose both accumulators, so any leak between them shows up. Broadcast modes are checked with operands that differ in every element. A wrong driver row or column therefore changes every affected result.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  typedef enum logic [3:0] {
    OP_NOP = 4'd0, OP_ADD = 4'd1, OP_SUB = 4'd2, OP_MUL = 4'd3,
    OP_CMP = 4'd4, OP_SEL = 4'd5, OP_MAC = 4'd6, OP_CLR = 4'd7,
    OP_MOV = 4'd8, OP_LD  = 4'd9
  } mtxOp_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_MUL, ALU_SEL, ALU_MOV, ALU_LD
  } aluSel_e;

  typedef enum logic [1:0] {
    BC_LOCAL = 2'd0, BC_ROW = 2'd1, BC_COL = 2'd2, BC_SCALAR = 2'd3
  } bcMode_e;

  typedef struct packed {
    logic    wrReg;
    logic    wrCc;
    logic    accEn;
    logic    accClr;
    logic    accSel;
    aluSel_e alu;
  } mtxCtl_t;
endpackage

// File: rtl/mtx_ctrl.sv
module mtx_ctrl
  import mtx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       instValid,
  input  logic [3:0] instOp,
  input  logic       accPick,
  output mtxCtl_t    ctl
);
  always_comb begin
    ctl        = '0;
    ctl.alu    = ALU_ADD;
    ctl.accSel = accPick;
    if (instValid) begin
      case (mtxOp_e'(instOp))
        OP_ADD: begin ctl.wrReg = 1'b1; ctl.alu = ALU_ADD; end
        OP_SUB: begin ctl.wrReg = 1'b1; ctl.alu = ALU_SUB; end
        OP_MUL: begin ctl.wrReg = 1'b1; ctl.alu = ALU_MUL; end
        OP_CMP: ctl.wrCc = 1'b1;
        OP_SEL: begin ctl.wrReg = 1'b1; ctl.alu = ALU_SEL; end
        OP_MAC: ctl.accEn  = 1'b1;
        OP_CLR: ctl.accClr = 1'b1;
        OP_MOV: begin ctl.wrReg = 1'b1; ctl.alu = ALU_MOV; end
        OP_LD:  begin ctl.wrReg = 1'b1; ctl.alu = ALU_LD; end
        default: ;
      endcase
    end
  end

  // R11: an idle slot raises no state-changing strobe
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !instValid |-> !(ctl.wrReg || ctl.wrCc || ctl.accEn || ctl.accClr));

  // R9: one instruction touches at most one kind of state
  p_single_effect_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.wrReg, ctl.wrCc, ctl.accEn, ctl.accClr}));
endmodule

// File: rtl/mtx_pe.sv
module mtx_pe
  import mtx_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 40,
  parameter int NREG = 16,
  parameter int NCC  = 4,
  localparam int RW  = $clog2(NREG),
  localparam int CW  = $clog2(NCC)
) (
  input  logic          clk,
  input  logic          rst,
  input  mtxCtl_t       ctl,
  input  logic [RW-1:0] dstIdx,
  input  logic [RW-1:0] srcAIdx,
  input  logic [RW-1:0] srcBIdx,
  input  logic [CW-1:0] ccIdx,
  input  logic [DW-1:0] opB,
  input  logic [DW-1:0] ldWord,
  input  logic [RW-1:0] rdIdx,
  output logic [DW-1:0] rdWord,
  output logic [DW-1:0] bcOut,
  output logic [NCC-1:0] ccOut
);
  logic [DW-1:0]  rf [NREG];
  logic [AW-1:0]  acc0, acc1;
  logic [NCC-1:0] cc;
  logic [DW-1:0]  opA, result;
  logic signed [AW-1:0] aExt, bExt, prod;
  logic [AW-1:0]  accCur;

  assign opA    = rf[srcAIdx];
  assign bcOut  = rf[srcBIdx];
  assign rdWord = rf[rdIdx];
  assign ccOut  = cc;
  assign aExt   = {{(AW-DW){opA[DW-1]}}, opA};
  assign bExt   = {{(AW-DW){opB[DW-1]}}, opB};
  assign prod   = aExt * bExt;
  assign accCur = ctl.accSel ? acc1 : acc0;

  always_comb begin
    case (ctl.alu)
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_MUL: result = prod[DW-1:0];
      ALU_SEL: result = cc[ccIdx] ? opA : opB;
      ALU_MOV: result = accCur[AW-1:AW-DW];
      ALU_LD:  result = ldWord;
      default: result = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (ctl.wrReg) begin
      rf[dstIdx] <= result;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc0 <= '0;
      acc1 <= '0;
    end else if (ctl.accClr) begin
      if (ctl.accSel) acc1 <= '0; else acc0 <= '0;
    end else if (ctl.accEn) begin
      if (ctl.accSel) acc1 <= acc1 + prod;
      else            acc0 <= acc0 + prod;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           cc <= '0;
    else if (ctl.wrCc) cc[ccIdx] <= ($signed(opA) < $signed(opB));
  end

  // R1: reset leaves accumulators and condition bits at zero
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (acc0 == '0 && acc1 == '0 && cc == '0));

  // R2: a load lands in the addressed register
  p_load_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (ctl.wrReg && ctl.alu == ALU_LD) |=> rf[$past(dstIdx)] == $past(ldWord));

  // R11: condition bits hold without a compare
  p_cc_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !ctl.wrCc |=> $stable(cc));

  // R10: a clear zeroes the chosen accumulator
  p_acc_clear_r10: assert property (@(posedge clk) disable iff (rst)
    ctl.accClr |=> (($past(ctl.accSel) ? acc1 : acc0) == '0));

  // R9: accumulating into one leaves the other unchanged
  p_acc_isolated_r9: assert property (@(posedge clk) disable iff (rst)
    ctl.accEn |=> ($past(ctl.accSel) ? $stable(acc0) : $stable(acc1)));
endmodule

// File: rtl/mtx_datapath.sv
module mtx_datapath
  import mtx_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 32,
  parameter int AW   = 40,
  parameter int NREG = 16,
  parameter int NCC  = 4,
  localparam int NPE = ROWS * COLS,
  localparam int RW  = $clog2(NREG),
  localparam int CW  = $clog2(NCC),
  localparam int BW  = $clog2((ROWS > COLS) ? ROWS : COLS)
) (
  input  logic            clk,
  input  logic            rst,
  input  mtxCtl_t         ctl,
  input  logic [RW-1:0]   instDst,
  input  logic [RW-1:0]   instSrcA,
  input  logic [RW-1:0]   instSrcB,
  input  logic [CW-1:0]   instCc,
  input  logic [1:0]      bcMode,
  input  logic [BW-1:0]   bcIdx,
  input  logic [DW-1:0]   instScalar,
  input  logic [NPE*DW-1:0] ldData,
  input  logic [RW-1:0]   rdIdx,
  output logic [NPE*DW-1:0] rdData,
  output logic [NPE*NCC-1:0] ccFlags
);
  logic [DW-1:0] bcWord [ROWS][COLS];
  logic [DW-1:0] rowBus [ROWS];
  logic [DW-1:0] colBus [COLS];

  for (genvar r = 0; r < ROWS; r++) begin : g_rowbus
    assign rowBus[r] = bcWord[r][bcIdx];
  end
  for (genvar c = 0; c < COLS; c++) begin : g_colbus
    assign colBus[c] = bcWord[bcIdx][c];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int E = r * COLS + c;
      logic [DW-1:0] opB;
      always_comb begin
        case (bcMode_e'(bcMode))
          BC_ROW:    opB = rowBus[r];
          BC_COL:    opB = colBus[c];
          BC_SCALAR: opB = instScalar;
          default:   opB = bcWord[r][c];
        endcase
      end
      mtx_pe #(.DW(DW), .AW(AW), .NREG(NREG), .NCC(NCC)) pe_i (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .dstIdx  (instDst),
        .srcAIdx (instSrcA),
        .srcBIdx (instSrcB),
        .ccIdx   (instCc),
        .opB     (opB),
        .ldWord  (ldData[E*DW +: DW]),
        .rdIdx   (rdIdx),
        .rdWord  (rdData[E*DW +: DW]),
        .bcOut   (bcWord[r][c]),
        .ccOut   (ccFlags[E*NCC +: NCC])
      );
    end
  end
endmodule

// File: rtl/mtx_grid_top.sv
module mtx_grid_top
  import mtx_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 32,
  parameter int AW   = 40,
  parameter int NREG = 16,
  parameter int NCC  = 4,
  localparam int NPE = ROWS * COLS,
  localparam int RW  = $clog2(NREG),
  localparam int CW  = $clog2(NCC),
  localparam int BW  = $clog2((ROWS > COLS) ? ROWS : COLS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instValid,
  input  logic [3:0]         instOp,
  input  logic [RW-1:0]      instDst,
  input  logic [RW-1:0]      instSrcA,
  input  logic [RW-1:0]      instSrcB,
  input  logic [CW-1:0]      instCc,
  input  logic [1:0]         bcMode,
  input  logic [BW-1:0]      bcIdx,
  input  logic [DW-1:0]      instScalar,
  input  logic [NPE*DW-1:0]  ldData,
  input  logic [RW-1:0]      rdIdx,
  output logic [NPE*DW-1:0]  rdData,
  output logic [NPE*NCC-1:0] ccFlags
);
  mtxCtl_t ctl;

  mtx_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .instValid (instValid),
    .instOp    (instOp),
    .accPick   (instCc[0]),
    .ctl       (ctl)
  );

  mtx_datapath #(
    .ROWS(ROWS), .COLS(COLS), .DW(DW), .AW(AW), .NREG(NREG), .NCC(NCC)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .instDst    (instDst),
    .instSrcA   (instSrcA),
    .instSrcB   (instSrcB),
    .instCc     (instCc),
    .bcMode     (bcMode),
    .bcIdx      (bcIdx),
    .instScalar (instScalar),
    .ldData     (ldData),
    .rdIdx      (rdIdx),
    .rdData     (rdData),
    .ccFlags    (ccFlags)
  );
endmodule

// File: tb/mtx_grid_top_tb_top.sv
`timescale 1ns/1ps
module mtx_grid_top_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         instValid = 1'b0;
  logic [3:0]   instOp = '0, instDst = '0, instSrcA = '0, instSrcB = '0;
  logic [1:0]   instCc = '0, bcMode = '0, bcIdx = '0;
  logic [31:0]  instScalar = '0;
  logic [511:0] ldData = '0;
  logic [3:0]   rdIdx = '0;
  logic [511:0] rdData;
  logic [63:0]  ccFlags;

  int total = 0, fails = 0;
  bit done = 0;

  logic [31:0] mReg [16][16];
  logic [39:0] mAcc [16][2];
  logic [3:0]  mCc  [16];

  always #2 clk = ~clk;

  mtx_grid_top dut_i (.*);

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] expMat(input int idx);
    logic [511:0] v;
    for (int e = 0; e < 16; e++) v[32*e +: 32] = mReg[e][idx];
    return v;
  endfunction

  function automatic logic [63:0] expFlags();
    logic [63:0] v;
    for (int e = 0; e < 16; e++) v[4*e +: 4] = mCc[e];
    return v;
  endfunction

  task automatic modelExec(input logic [3:0] op, d, a, b, input logic [1:0] cc, bm, bi,
                           input logic [31:0] sc, input logic [511:0] ld);
    logic [31:0] oReg [16][16];
    oReg = mReg;
    for (int e = 0; e < 16; e++) begin
      int r = e / 4;
      int c = e % 4;
      logic [31:0] av, bv;
      longint pl;
      av = oReg[e][a];
      case (bm)
        2'd1:    bv = oReg[r*4 + int'(bi)][b];
        2'd2:    bv = oReg[int'(bi)*4 + c][b];
        2'd3:    bv = sc;
        default: bv = oReg[e][b];
      endcase
      pl = longint'(int'(av)) * longint'(int'(bv));
      case (op)
        4'd1: mReg[e][d] = av + bv;
        4'd2: mReg[e][d] = av - bv;
        4'd3: mReg[e][d] = pl[31:0];
        4'd4: mCc[e][cc] = (int'(av) < int'(bv));
        4'd5: mReg[e][d] = mCc[e][cc] ? av : bv;
        4'd6: mAcc[e][cc[0]] = mAcc[e][cc[0]] + pl[39:0];
        4'd7: mAcc[e][cc[0]] = '0;
        4'd8: mReg[e][d] = mAcc[e][cc[0]][39:8];
        4'd9: mReg[e][d] = ld[32*e +: 32];
        default: ;
      endcase
    end
  endtask

  task automatic step(input string req, input logic v, input logic [3:0] op, d, a, b,
                      input logic [1:0] cc, bm, bi, input logic [31:0] sc, input logic [511:0] ld);
    @(negedge clk);
    instValid = v; instOp = op; instDst = d; instSrcA = a; instSrcB = b;
    instCc = cc; bcMode = bm; bcIdx = bi; instScalar = sc; ldData = ld; rdIdx = d;
    if (v) modelExec(op, d, a, b, cc, bm, bi, sc, ld);
    @(posedge clk); #1;
    check(req, rdData, expMat(int'(d)));
    check(req, {448'd0, ccFlags}, {448'd0, expFlags()});
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      instValid = 1'b0; rdIdx = 4'(i);
      #1 check(req, rdData, expMat(i));
    end
  endtask

  function automatic logic [511:0] pat(input logic [31:0] base, input logic [31:0] stepv);
    logic [511:0] v;
    for (int e = 0; e < 16; e++) v[32*e +: 32] = base + stepv * 32'(e);
    return v;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 16; e++) begin
      for (int k = 0; k < 16; k++) mReg[e][k] = '0;
      mAcc[e][0] = '0; mAcc[e][1] = '0; mCc[e] = '0;
    end
    // preload registers before reset so the clear is visible (R1)
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    instValid = 1; instOp = 4'd9; instDst = 4'd5; ldData = pat(32'h1111, 32'h3);
    @(negedge clk);
    instValid = 0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    sweep("R1");
    check("R1", {448'd0, ccFlags}, 512'd0);
    step("R1", 1, 4'd8, 4'd0, 4'd0, 4'd0, 2'd0, 2'd0, 2'd0, 0, 0);
    step("R1", 1, 4'd8, 4'd0, 4'd0, 4'd0, 2'd1, 2'd0, 2'd0, 0, 0);

    // R2: loads and read-back mapping
    step("R2", 1, 4'd9, 4'd1, 0, 0, 0, 0, 0, 0, pat(32'h0000_0100, 32'h0101_0003));
    step("R2", 1, 4'd9, 4'd2, 0, 0, 0, 0, 0, 0, pat(32'hFFFF_FFF0, 32'hFFFF_FFFD));
    step("R2", 1, 4'd9, 4'd8, 0, 0, 0, 0, 0, 0, {16{32'h7FFF_FFFF}});
    step("R2", 1, 4'd9, 4'd11, 0, 0, 0, 0, 0, 0, {8{32'h8000_0000, 32'h7FFF_FFFF}});
    sweep("R2");

    // R3: element-wise arithmetic with wrap
    step("R3", 1, 4'd1, 4'd3, 4'd1, 4'd2, 0, 0, 0, 0, 0);
    step("R3", 1, 4'd2, 4'd4, 4'd2, 4'd1, 0, 0, 0, 0, 0);
    step("R3", 1, 4'd3, 4'd5, 4'd1, 4'd2, 0, 0, 0, 0, 0);
    step("R3", 1, 4'd1, 4'd6, 4'd8, 4'd8, 0, 0, 0, 0, 0);
    step("R3", 1, 4'd3, 4'd7, 4'd11, 4'd8, 0, 0, 0, 0, 0);

    // R4, R5, R6: broadcast sources
    step("R4", 1, 4'd1, 4'd12, 4'd1, 4'd2, 0, 2'd1, 2'd2, 0, 0);
    step("R4", 1, 4'd2, 4'd12, 4'd1, 4'd1, 0, 2'd1, 2'd0, 0, 0);
    step("R5", 1, 4'd1, 4'd13, 4'd1, 4'd2, 0, 2'd2, 2'd1, 0, 0);
    step("R5", 1, 4'd3, 4'd13, 4'd2, 4'd1, 0, 2'd2, 2'd3, 0, 0);
    step("R6", 1, 4'd3, 4'd14, 4'd1, 4'd0, 0, 2'd3, 0, 32'hFFFF_FFFE, 0);
    step("R6", 1, 4'd1, 4'd14, 4'd2, 4'd0, 0, 2'd3, 0, 32'h0000_0020, 0);

    // R7, R8: compare then select
    step("R7", 1, 4'd4, 4'd1, 4'd1, 4'd2, 2'd2, 0, 0, 0, 0);
    step("R7", 1, 4'd4, 4'd1, 4'd2, 4'd1, 2'd0, 2'd1, 2'd3, 0, 0);
    step("R7", 1, 4'd4, 4'd1, 4'd11, 4'd8, 2'd3, 0, 0, 0, 0);
    step("R8", 1, 4'd5, 4'd15, 4'd1, 4'd2, 2'd2, 0, 0, 0, 0);
    step("R8", 1, 4'd5, 4'd15, 4'd11, 4'd8, 2'd0, 2'd3, 0, 32'h1234_5678, 0);

    // R9: accumulation with 40-bit wrap, two independent accumulators
    for (int i = 0; i < 6; i++)
      step("R9", 1, 4'd6, 4'd0, 4'd8, 4'd11, 2'd0, 0, 0, 0, 0);
    step("R9", 1, 4'd6, 4'd0, 4'd1, 4'd2, 2'd1, 0, 0, 0, 0);
    step("R9", 1, 4'd6, 4'd0, 4'd2, 4'd2, 2'd1, 2'd1, 2'd1, 0, 0);
    step("R9", 1, 4'd8, 4'd9, 0, 0, 2'd0, 0, 0, 0, 0);
    step("R9", 1, 4'd8, 4'd10, 0, 0, 2'd1, 0, 0, 0, 0);

    // R10: clear one accumulator, move both
    step("R10", 1, 4'd7, 4'd0, 0, 0, 2'd0, 0, 0, 0, 0);
    step("R10", 1, 4'd8, 4'd9, 0, 0, 2'd0, 0, 0, 0, 0);
    step("R10", 1, 4'd8, 4'd10, 0, 0, 2'd1, 0, 0, 0, 0);

    // R11: idle slot and no-op change nothing
    step("R11", 0, 4'd9, 4'd1, 0, 0, 0, 0, 0, 0, {16{32'hDEAD_BEEF}});
    step("R11", 0, 4'd4, 4'd1, 4'd2, 4'd1, 2'd1, 0, 0, 0, 0);
    step("R11", 0, 4'd6, 4'd0, 4'd8, 4'd8, 2'd1, 0, 0, 0, 0);
    step("R11", 1, 4'd0, 4'd2, 4'd1, 4'd1, 2'd2, 0, 0, 0, 0);
    step("R11", 1, 4'd8, 4'd10, 0, 0, 2'd1, 0, 0, 0, 0);

    // mixed stream across all opcodes and modes
    for (int i = 0; i < 300; i++) begin
      logic [511:0] ld;
      for (int w = 0; w < 16; w++) ld[32*w +: 32] = $urandom();
      step("R3", ($urandom() % 8) != 0, 4'($urandom() % 11), 4'($urandom()), 4'($urandom()),
           4'($urandom()), 2'($urandom()), 2'($urandom()), 2'($urandom()), $urandom(), ld);
    end
    sweep("R2");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule